// File: doc/BRIEF.md
# CAN Fault Confinement Controller

This block tracks how reliable a CAN node has been on the bus. It holds a transmit error counter and a receive error counter, and it classifies the node as error-active, error-passive or bus-off. The protocol engine drives it with one-cycle event pulses. Error events raise a counter. Successful transmissions and receptions lower a counter. While the node is bus-off, the engine also sends one pulse for each sampled recessive bit and one for each sampled dominant bit.

Once the node has seen 128 completed runs of 11 consecutive recessive bits, it leaves bus-off with both counters at zero. Both counters are outputs and can be read at any time. A sticky status-change interrupt flags every transition of the passive or bus-off flag, provided the interrupt is enabled. Software clears it with a one-cycle pulse.

Top module: `can_fault_guard`

## Requirements
- R1: After reset both counters read 0 and the passive flag, the bus-off flag and the interrupt are all 0.
- R2: Each pulse on `tx_err` adds 8 to the transmit counter, and each pulse on `tx_ok` subtracts 1. The value is visible on `tec` on the cycle after the pulse. Subtracting at 0 leaves 0. When both pulses arrive in the same cycle, only the addition is applied.
- R3: Each pulse on `rx_err` adds 1 to the receive counter, a pulse on `rx_err_major` adds 8, and a pulse on `rx_ok` subtracts 1. Subtracting at 0 leaves 0. When several of these arrive in the same cycle, only one is applied, in the priority order `rx_err_major`, then `rx_err`, then `rx_ok`. Additions saturate at 511.
- R4: `err_passive` becomes 1 in the same cycle that either counter reaches 128 or more, as long as the node is not bus-off.
- R5: `err_passive` returns to 0 only once both counters are 127 or less.
- R6: When the transmit counter reaches 256 or more, `bus_off` becomes 1 and `err_passive` becomes 0 in that same cycle.
- R7: While `bus_off` is 1, all counter event pulses are ignored and both counters hold their values.
- R8: While bus-off, the recovery completes on the recessive pulse that ends the 128th run of 11 consecutive recessive pulses. On the next cycle, `bus_off`, `tec` and `rec` all read 0. Recessive pulses received outside bus-off are not counted.
- R9: A `dominant_bit` pulse during bus-off restarts the current 11-bit run but keeps the count of completed runs. If a recessive and a dominant pulse arrive together, the dominant pulse wins.
- R10: When `irq_en` is 1, any change of `err_passive` or `bus_off` sets `irq`. `irq` then stays set until an `irq_clr` pulse. If a new change and `irq_clr` arrive in the same cycle, the set wins. When `irq_en` is 0, a flag change does not set `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_err | input | 1 | Transmit error event, +8 |
| tx_ok | input | 1 | Successful transmission, -1 |
| rx_err | input | 1 | Receive error event, +1 |
| rx_err_major | input | 1 | Severe receive error event, +8 |
| rx_ok | input | 1 | Successful reception, -1 |
| recessive_bit | input | 1 | One recessive bit sampled |
| dominant_bit | input | 1 | One dominant bit sampled |
| irq_en | input | 1 | Status-change interrupt enable |
| irq_clr | input | 1 | Interrupt acknowledge pulse |
| tec | output | 9 | Transmit error counter |
| rec | output | 9 | Receive error counter |
| err_passive | output | 1 | Node is error-passive |
| bus_off | output | 1 | Node is bus-off |
| irq | output | 1 | Sticky status-change interrupt request |

## Verification
The transmit counter is stepped one error at a time from 0 up to 256. This separates the 120 to 128 passive threshold from the 248 to 256 bus-off threshold. The receive counter is swept upward by single steps to 128 and then downward to 0 plus one extra decrement, which exposes any threshold or saturation off-by-one.

Simultaneous event pulses are applied to pin down the priority rules. Each counter is driven passive on its own while the other sits high, to tell the "either" set rule apart from the "both" clear rule. The recovery is tested with a broken run and with a run that is one recessive bit short, so that a design counting raw bits can be told apart from one that counts complete runs.

// File: rtl/fc_pkg.sv
package fc_pkg;
  typedef enum logic [1:0] {
    NODE_ACTIVE  = 2'd0,
    NODE_PASSIVE = 2'd1,
    NODE_BUSOFF  = 2'd2
  } node_state_e;
endpackage

// File: rtl/fc_err_counter.sv
module fc_err_counter #(
  parameter int W     = 9,
  parameter int SMALL = 1,
  parameter int BIG   = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold,
  input  logic         clr,
  input  logic         inc_small,
  input  logic         inc_big,
  input  logic         dec,
  output logic [W-1:0] count,
  output logic [W-1:0] count_next
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic [W-1:0] q;
  logic [W:0]   sum_big;
  logic [W:0]   sum_small;

  assign sum_big   = {1'b0, q} + (W+1)'(BIG);
  assign sum_small = {1'b0, q} + (W+1)'(SMALL);

  always_comb begin
    count_next = q;
    if (clr) begin
      count_next = '0;
    end else if (!hold) begin
      if (inc_big) begin
        count_next = sum_big[W] ? MAXV : sum_big[W-1:0];
      end else if (inc_small) begin
        count_next = sum_small[W] ? MAXV : sum_small[W-1:0];
      end else if (dec && (q != '0)) begin
        count_next = q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= count_next;
  end

  assign count = q;

  p_no_underflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (q == '0 && dec && !inc_small && !inc_big && !hold) |=> (q == '0));

  p_hold_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !clr) |=> $stable(q));
endmodule

// File: rtl/fc_busoff_recovery.sv
module fc_busoff_recovery #(
  parameter int RUN_LEN   = 11,
  parameter int RUN_COUNT = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic recessive_bit,
  input  logic dominant_bit,
  output logic done
);
  localparam int RUN_W = $clog2(RUN_LEN);
  localparam int SEQ_W = $clog2(RUN_COUNT);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_LEN - 1);
  localparam logic [SEQ_W-1:0] SEQ_LAST = SEQ_W'(RUN_COUNT - 1);

  logic [RUN_W-1:0] run_q, run_n;
  logic [SEQ_W-1:0] seq_q, seq_n;
  logic             run_end;

  assign run_end = active && recessive_bit && !dominant_bit && (run_q == RUN_LAST);
  assign done    = run_end && (seq_q == SEQ_LAST);

  always_comb begin
    run_n = run_q;
    seq_n = seq_q;
    if (!active || done) begin
      run_n = '0;
      seq_n = '0;
    end else if (dominant_bit) begin
      run_n = '0;
    end else if (recessive_bit) begin
      if (run_end) begin
        run_n = '0;
        seq_n = seq_q + 1'b1;
      end else begin
        run_n = run_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      seq_q <= '0;
    end else begin
      run_q <= run_n;
      seq_q <= seq_n;
    end
  end

  p_run_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RUN_LAST);

  p_dominant_restarts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && dominant_bit) |=> (run_q == '0 && $stable(seq_q)));
endmodule

// File: rtl/can_fault_guard.sv
module can_fault_guard #(
  parameter int CNT_W       = 9,
  parameter int PASSIVE_LIM = 128,
  parameter int BUSOFF_LIM  = 256,
  parameter int RUN_LEN     = 11,
  parameter int RUN_COUNT   = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_err,
  input  logic             tx_ok,
  input  logic             rx_err,
  input  logic             rx_err_major,
  input  logic             rx_ok,
  input  logic             recessive_bit,
  input  logic             dominant_bit,
  input  logic             irq_en,
  input  logic             irq_clr,
  output logic [CNT_W-1:0] tec,
  output logic [CNT_W-1:0] rec,
  output logic             err_passive,
  output logic             bus_off,
  output logic             irq
);
  import fc_pkg::*;

  localparam logic [CNT_W-1:0] PASSIVE_AT = CNT_W'(PASSIVE_LIM);
  localparam logic [CNT_W-1:0] BUSOFF_AT  = CNT_W'(BUSOFF_LIM);

  node_state_e      state_q, state_n;
  logic             irq_q, irq_n;
  logic             recovered;
  logic             frozen;
  logic [CNT_W-1:0] tec_n, rec_n;

  assign frozen = (state_q == NODE_BUSOFF);

  fc_err_counter #(.W(CNT_W), .SMALL(1), .BIG(8)) u_tec (
    .clk(clk), .rst_n(rst_n), .hold(frozen), .clr(recovered),
    .inc_small(1'b0), .inc_big(tx_err), .dec(tx_ok),
    .count(tec), .count_next(tec_n)
  );

  fc_err_counter #(.W(CNT_W), .SMALL(1), .BIG(8)) u_rec (
    .clk(clk), .rst_n(rst_n), .hold(frozen), .clr(recovered),
    .inc_small(rx_err), .inc_big(rx_err_major), .dec(rx_ok),
    .count(rec), .count_next(rec_n)
  );

  fc_busoff_recovery #(.RUN_LEN(RUN_LEN), .RUN_COUNT(RUN_COUNT)) u_recov (
    .clk(clk), .rst_n(rst_n), .active(frozen),
    .recessive_bit(recessive_bit), .dominant_bit(dominant_bit),
    .done(recovered)
  );

  always_comb begin
    state_n = state_q;
    if (frozen) begin
      if (recovered) state_n = NODE_ACTIVE;
    end else if (tec_n >= BUSOFF_AT) begin
      state_n = NODE_BUSOFF;
    end else if ((tec_n >= PASSIVE_AT) || (rec_n >= PASSIVE_AT)) begin
      state_n = NODE_PASSIVE;
    end else begin
      state_n = NODE_ACTIVE;
    end
  end

  always_comb begin
    irq_n = irq_q;
    if (irq_clr) irq_n = 1'b0;
    if (irq_en && (state_n != state_q)) irq_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= NODE_ACTIVE;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      irq_q   <= irq_n;
    end
  end

  assign err_passive = (state_q == NODE_PASSIVE);
  assign bus_off     = (state_q == NODE_BUSOFF);
  assign irq         = irq_q;

  p_busoff_not_passive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_off) |-> (!err_passive && tec >= BUSOFF_AT));

  p_recovery_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_off) |-> (tec == '0 && rec == '0 && !err_passive));

  p_passive_needs_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err_passive |-> (tec >= PASSIVE_AT || rec >= PASSIVE_AT));

  p_irq_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(irq_en));

  p_irq_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);
endmodule

// File: tb/sim_can_fault_guard.sv
module sim_can_fault_guard;
  logic clk = 1'b0;
  logic rst_n;
  logic tx_err, tx_ok, rx_err, rx_err_major, rx_ok;
  logic recessive_bit, dominant_bit, irq_en, irq_clr;
  logic [8:0] tec, rec;
  logic err_passive, bus_off, irq;

  int n_checks = 0;
  int n_fail   = 0;
  int exp_tec  = 0;
  int exp_rec  = 0;

  always #5 clk = ~clk;

  can_fault_guard u0 (
    .clk(clk), .rst_n(rst_n), .tx_err(tx_err), .tx_ok(tx_ok), .rx_err(rx_err),
    .rx_err_major(rx_err_major), .rx_ok(rx_ok), .recessive_bit(recessive_bit),
    .dominant_bit(dominant_bit), .irq_en(irq_en), .irq_clr(irq_clr),
    .tec(tec), .rec(rec), .err_passive(err_passive), .bus_off(bus_off), .irq(irq)
  );

  task automatic check(input string req, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  task automatic idle();
    tx_err = 0; tx_ok = 0; rx_err = 0; rx_err_major = 0; rx_ok = 0;
    recessive_bit = 0; dominant_bit = 0; irq_clr = 0;
  endtask

  // Drive one pulse (bit mask) for one cycle; outputs are sampled after the next negedge.
  // mask: 0 tx_err, 1 tx_ok, 2 rx_err, 3 rx_err_major, 4 rx_ok, 5 recessive, 6 dominant, 7 irq_clr
  task automatic pulse(input logic [7:0] m);
    @(negedge clk);
    tx_err = m[0]; tx_ok = m[1]; rx_err = m[2]; rx_err_major = m[3];
    rx_ok = m[4]; recessive_bit = m[5]; dominant_bit = m[6]; irq_clr = m[7];
    @(negedge clk);
    idle();
  endtask

  task automatic check_state(input string req);
    int pas;
    int bo;
    bo  = (exp_tec >= 256) ? 1 : 0;
    pas = (!bo && (exp_tec >= 128 || exp_rec >= 128)) ? 1 : 0;
    check({req, " tec"}, int'(tec), exp_tec);
    check({req, " rec"}, int'(rec), exp_rec);
    check({req, " passive"}, int'(err_passive), pas);
    check({req, " busoff"}, int'(bus_off), bo);
  endtask

  initial begin
    #1500000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    idle();
    irq_en = 0;
    rst_n  = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 tec", int'(tec), 0);
    check("R1 rec", int'(rec), 0);
    check("R1 passive", int'(err_passive), 0);
    check("R1 busoff", int'(bus_off), 0);
    check("R1 irq", int'(irq), 0);

    // R2 decrement at zero saturates
    pulse(8'h02); check_state("R2 sat0");
    // R8 recessive bits outside bus-off are not counted
    for (int i = 0; i < 30; i++) pulse(8'h20);
    check_state("R8 idle recessive");

    // R3/R4 receive counter sweep up, irq disabled (R10)
    for (int i = 1; i <= 128; i++) begin
      pulse(8'h04); exp_rec = i; check_state("R3/R4 rx sweep");
    end
    check("R10 irq disabled", int'(irq), 0);
    // R2 transmit errors while rec passive
    for (int i = 1; i <= 17; i++) begin
      pulse(8'h01); exp_tec = 8 * i; check_state("R2 tx up");
    end
    // R5 rec drops below, tec still high: stays passive
    pulse(8'h10); exp_rec = 127; check_state("R5 rec127");
    for (int i = 1; i <= 9; i++) begin
      pulse(8'h02); exp_tec = 136 - i; check_state("R5 tx down");
    end
    // R3 priorities
    pulse(8'h08); exp_rec = 135; check_state("R3 major");
    pulse(8'h0C); exp_rec = 143; check_state("R3 major over minor");
    pulse(8'h14); exp_rec = 144; check_state("R3 err over ok");
    for (int i = 1; i <= 145; i++) begin
      pulse(8'h10); exp_rec = (144 - i < 0) ? 0 : 144 - i; check_state("R3 rx down");
    end
    for (int i = 1; i <= 127; i++) begin
      pulse(8'h02); exp_tec = 127 - i;
    end
    check_state("R2 tx to zero");
    pulse(8'h03); exp_tec = 8; check_state("R2 err over ok");
    for (int i = 0; i < 8; i++) pulse(8'h02);
    exp_tec = 0; check_state("R2 back to zero");

    // R10 with enable
    irq_en = 1;
    for (int i = 1; i <= 16; i++) begin
      pulse(8'h01); exp_tec = 8 * i; check_state("R4 tx passive");
      check("R10 irq", int'(irq), (i == 16) ? 1 : 0);
    end
    pulse(8'h80); check("R10 clear", int'(irq), 0);
    pulse(8'h04); exp_rec = 1; check_state("R10 no change");
    check("R10 no change irq", int'(irq), 0);
    for (int i = 17; i <= 32; i++) begin
      pulse(8'h01); exp_tec = 8 * i; check_state("R6 tx to busoff");
      check("R10 irq busoff", int'(irq), (i == 32) ? 1 : 0);
    end
    pulse(8'h80); check("R10 clear2", int'(irq), 0);

    // R7 events ignored during bus-off
    pulse(8'h01); pulse(8'h02); pulse(8'h04); pulse(8'h08); pulse(8'h10);
    check_state("R7 frozen");
    check("R7 irq quiet", int'(irq), 0);

    // R9 broken run does not count
    for (int i = 0; i < 5; i++) pulse(8'h20);
    pulse(8'h40);
    for (int i = 0; i < 127 * 11; i++) pulse(8'h20);
    for (int i = 0; i < 10; i++) pulse(8'h20);
    check_state("R8 one short");
    pulse(8'h60);  // recessive and dominant together: dominant wins
    for (int i = 0; i < 10; i++) pulse(8'h20);
    check_state("R9 run restarted");
    pulse(8'h20);
    exp_tec = 0; exp_rec = 0;
    check_state("R8 recovered");
    check("R10 irq recovery", int'(irq), 1);
    pulse(8'h80); check("R10 clear3", int'(irq), 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule